// File: doc/BRIEF.md
# Multi-Class Bus Wait-State Generator

This block stretches CPU bus cycles by holding an active-low wait output for a configured number of bus clocks. Each new cycle is sorted into one of three classes: boot-ROM access, general memory access, or port I/O access. Each class has its own static wait count. A mode selector decides which cycles the general memory count covers: interrupt-acknowledge cycles only, opcode fetches only, or every memory cycle.

The CPU-side strobes are active low: memory request, I/O request and machine-cycle-one. An opcode fetch is a memory request with machine-cycle-one low. An interrupt acknowledge is an I/O request with machine-cycle-one low. An address decoder outside this block supplies the ROM select. The counter loads when a cycle starts and counts down once per clock. When the strobes are released, the wait output goes high at once and the count is cleared.

Top module: `bus_wait_gen`

## Requirements
- R1: After synchronous reset (rst high), wait_n reads 1 while no strobe is active.
- R2: A cycle with mreq_n low and rom_sel high stalls for cfg_rom_waits clocks, for any value from 0 to 8.
- R3: A cycle with iorq_n low and m1_n high (port I/O) stalls for cfg_io_waits clocks.
- R4: With cfg_mem_mode = 0, an interrupt acknowledge (iorq_n low, m1_n low) stalls for cfg_mem_waits clocks. Non-ROM memory cycles do not stall.
- R5: With cfg_mem_mode = 1, a non-ROM opcode fetch (mreq_n low, m1_n low) stalls for cfg_mem_waits clocks. Other non-ROM memory cycles and interrupt acknowledges do not stall.
- R6: With cfg_mem_mode = 2 or 3, every non-ROM memory cycle stalls for cfg_mem_waits clocks. Interrupt acknowledges do not stall.
- R7: A memory cycle with rom_sel high uses the ROM count even when the memory class also matches it.
- R8: A selected count of 0 leaves wait_n at 1 for the whole cycle.
- R9: Any count value above 8 acts as 8.
- R10: wait_n is 1 in the first clock a strobe is active. For a count N, it is then 0 for exactly N consecutive clocks and returns to 1 while the strobe is still held.
- R11: When both mreq_n and iorq_n go high, wait_n is 1 in that same clock. The next cycle stalls only for its own count, with nothing carried over from an aborted cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| mreq_n | input | 1 | Memory request strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| m1_n | input | 1 | Machine-cycle-one (fetch or acknowledge), active low |
| rom_sel | input | 1 | Boot-ROM address decode, active high |
| cfg_mem_mode | input | 2 | Memory-class mode: 0 acknowledge, 1 fetch, 2/3 all memory |
| cfg_rom_waits | input | 4 | Wait count for ROM cycles |
| cfg_mem_waits | input | 4 | Wait count for the selected memory cycles |
| cfg_io_waits | input | 4 | Wait count for port I/O cycles |
| wait_n | output | 1 | Wait request, active low |

## Verification
The clock edge that first sees an active strobe loads the counter. wait_n therefore falls one clock after the strobe falls and stays low for N clocks. wait_n rises combinationally in the clock in which the strobes are released. The bench changes inputs on the falling edge and samples 1 ns later. For each cycle it counts the low samples from the first active sample through the first idle one, so it checks the start-clock high, the contiguous stall window and the immediate release together. Each cycle is held well beyond the largest count, and the abort case releases the strobe partway through its stall window.

// File: rtl/ws_pkg.sv
package ws_pkg;

    localparam int WS_CNT_W = 4;
    localparam int WS_MAX   = 8;

    typedef enum logic [1:0] {
        MM_INTA  = 2'd0,
        MM_FETCH = 2'd1,
        MM_ALL   = 2'd2,
        MM_ALL2  = 2'd3
    } mem_mode_e;

    typedef enum logic [1:0] {
        CL_NONE,
        CL_ROM,
        CL_MEM,
        CL_IO
    } cyc_class_e;

    typedef struct packed {
        logic mem;
        logic io;
        logic m1;
        logic rom;
    } strobes_t;

    function automatic cyc_class_e classify(input strobes_t s, input mem_mode_e m);
        cyc_class_e c;
        c = CL_NONE;
        if (s.mem && s.rom) begin
            c = CL_ROM;
        end else if (s.mem) begin
            case (m)
                MM_INTA:  c = CL_NONE;
                MM_FETCH: c = s.m1 ? CL_MEM : CL_NONE;
                default:  c = CL_MEM;
            endcase
        end else if (s.io) begin
            if (s.m1) c = (m == MM_INTA) ? CL_MEM : CL_NONE;
            else      c = CL_IO;
        end
        return c;
    endfunction

endpackage

// File: rtl/ws_classify.sv
module ws_classify
    import ws_pkg::*;
#(
    parameter int CNT_W     = WS_CNT_W,
    parameter int MAX_WAITS = WS_MAX
) (
    input  strobes_t           strb,
    input  mem_mode_e          mode,
    input  logic [CNT_W-1:0]   rom_waits,
    input  logic [CNT_W-1:0]   mem_waits,
    input  logic [CNT_W-1:0]   io_waits,
    output logic [CNT_W-1:0]   load
);
    localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_WAITS);

    function automatic logic [CNT_W-1:0] clamp(input logic [CNT_W-1:0] v);
        return (v > MAX_V) ? MAX_V : v;
    endfunction

    cyc_class_e cls;

    always_comb begin
        cls = classify(strb, mode);
        case (cls)
            CL_ROM:  load = clamp(rom_waits);
            CL_MEM:  load = clamp(mem_waits);
            CL_IO:   load = clamp(io_waits);
            default: load = '0;
        endcase
    end

endmodule

// File: rtl/ws_count.sv
module ws_count #(
    parameter int CNT_W     = 4,
    parameter int MAX_WAITS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [CNT_W-1:0] load,
    output logic             wait_n
);
    logic [CNT_W-1:0] cnt;
    logic             active_q;
    logic             start;

    assign start  = active && !active_q;
    assign wait_n = !(active && (cnt != '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            active_q <= 1'b0;
        end else begin
            active_q <= active;
            if (start)            cnt <= load;
            else if (!active)     cnt <= '0;
            else if (cnt != '0)   cnt <= cnt - 1'b1;
        end
    end

    // R11: idle strobes leave no count behind
    a_r11_clear_on_idle: assert property (@(posedge clk) disable iff (rst)
        !active |=> (cnt == '0));

    // R10: one step down per clock while the cycle is held
    a_r10_step_down: assert property (@(posedge clk) disable iff (rst)
        (active && (cnt != '0)) |=> (cnt == $past(cnt) - 1'b1));

    // R8: a zero load never stalls
    a_r8_zero_no_stall: assert property (@(posedge clk) disable iff (rst)
        (start && (load == '0)) |=> wait_n);

    // R9: counter never exceeds the ceiling
    a_r9_ceiling: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(MAX_WAITS));

endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen
    import ws_pkg::*;
#(
    parameter int CNT_W     = WS_CNT_W,
    parameter int MAX_WAITS = WS_MAX
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mreq_n,
    input  logic             iorq_n,
    input  logic             m1_n,
    input  logic             rom_sel,
    input  logic [1:0]       cfg_mem_mode,
    input  logic [CNT_W-1:0] cfg_rom_waits,
    input  logic [CNT_W-1:0] cfg_mem_waits,
    input  logic [CNT_W-1:0] cfg_io_waits,
    output logic             wait_n
);
    strobes_t         strb;
    logic [CNT_W-1:0] load;
    logic             active;

    always_comb begin
        strb.mem = !mreq_n;
        strb.io  = !iorq_n;
        strb.m1  = !m1_n;
        strb.rom = rom_sel;
    end

    assign active = strb.mem || strb.io;

    ws_classify #(.CNT_W(CNT_W), .MAX_WAITS(MAX_WAITS)) u_cls (
        .strb      (strb),
        .mode      (mem_mode_e'(cfg_mem_mode)),
        .rom_waits (cfg_rom_waits),
        .mem_waits (cfg_mem_waits),
        .io_waits  (cfg_io_waits),
        .load      (load)
    );

    ws_count #(.CNT_W(CNT_W), .MAX_WAITS(MAX_WAITS)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .load   (load),
        .wait_n (wait_n)
    );

    // R1: no stall outside a bus cycle
    a_r1_idle_ready: assert property (@(posedge clk) disable iff (rst)
        (mreq_n && iorq_n) |-> wait_n);

endmodule

// File: tb/tb_bus_wait_gen.sv
module tb_bus_wait_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mreq_n = 1'b1, iorq_n = 1'b1, m1_n = 1'b1, rom_sel = 1'b0;
    logic [1:0] cfg_mem_mode = 2'd1;
    logic [3:0] cfg_rom_waits = 4'd1, cfg_mem_waits = 4'd1, cfg_io_waits = 4'd2;
    logic       wait_n;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;
    int    exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    bus_wait_gen dut (
        .clk(clk), .rst(rst), .mreq_n(mreq_n), .iorq_n(iorq_n), .m1_n(m1_n),
        .rom_sel(rom_sel), .cfg_mem_mode(cfg_mem_mode), .cfg_rom_waits(cfg_rom_waits),
        .cfg_mem_waits(cfg_mem_waits), .cfg_io_waits(cfg_io_waits), .wait_n(wait_n)
    );

    task automatic run(input logic mq, input logic iq, input logic m1, input logic rs,
                       input int hold, input int exp, input string tag);
        @(negedge clk);
        mreq_n = mq; iorq_n = iq; m1_n = m1; rom_sel = rs;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        repeat (hold) @(negedge clk);
        mreq_n = 1'b1; iorq_n = 1'b1; m1_n = 1'b1; rom_sel = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic cfg(input logic [1:0] mode, input logic [3:0] r,
                       input logic [3:0] m, input logic [3:0] io);
        @(negedge clk);
        cfg_mem_mode = mode; cfg_rom_waits = r; cfg_mem_waits = m; cfg_io_waits = io;
    endtask

    // monitor: counts stalls per cycle and compares against the scoreboard
    initial begin
        bit    in_cyc = 0, ended = 0, bad = 0;
        int    stalls = 0;
        int    e;
        string t;
        forever begin
            @(negedge clk);
            #1;
            if (rst) continue;
            if (!mreq_n || !iorq_n) begin
                if (!in_cyc) begin
                    in_cyc = 1; stalls = 0; ended = 0; bad = !wait_n;
                end else if (!wait_n) begin
                    if (ended) bad = 1;
                    stalls++;
                end else if (stalls > 0) begin
                    ended = 1;
                end
            end else begin
                if (in_cyc) begin
                    in_cyc = 0;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    checks++;
                    if (stalls != e || bad || !wait_n) begin
                        errors++;
                        $display("FAIL %s (R10/R11 window): stalls=%0d exp=%0d gap_or_early=%0d release_wait_n=%0d exp_release=1",
                                 t, stalls, e, bad, wait_n);
                    end
                end else if (!wait_n) begin
                    checks++; errors++;
                    $display("FAIL R11 idle: wait_n=%0d exp=1", wait_n);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: finished=0 exp=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        checks++;
        if (wait_n !== 1'b1) begin
            errors++; $display("FAIL R1 in reset: wait_n=%0d exp=1", wait_n);
        end
        @(negedge clk); rst = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        checks++;
        if (wait_n !== 1'b1) begin
            errors++; $display("FAIL R1 after reset: wait_n=%0d exp=1", wait_n);
        end

        // fetch-only mode, rom 1, mem 1, io 2
        cfg(2'd1, 4'd1, 4'd1, 4'd2);
        run(0, 1, 0, 1, 12, 1, "R2 R7 rom fetch");
        run(0, 1, 0, 0, 12, 1, "R5 mem fetch");
        run(0, 1, 1, 0, 12, 0, "R5 mem read");
        run(1, 0, 1, 0, 12, 2, "R3 io");
        run(1, 0, 0, 0, 12, 0, "R5 inta");

        cfg(2'd1, 4'd8, 4'd1, 4'd0);
        run(0, 1, 1, 1, 12, 8, "R2 rom max");
        run(1, 0, 1, 0, 12, 0, "R8 io zero");
        cfg(2'd1, 4'd0, 4'd1, 4'd15);
        run(0, 1, 1, 1, 12, 0, "R8 rom zero");
        run(1, 0, 1, 0, 12, 8, "R9 io clamp");
        cfg(2'd1, 4'd12, 4'd1, 4'd2);
        run(0, 1, 0, 1, 12, 8, "R9 rom clamp");

        // acknowledge mode
        cfg(2'd0, 4'd1, 4'd3, 4'd2);
        run(1, 0, 0, 0, 12, 3, "R4 inta");
        run(0, 1, 0, 0, 12, 0, "R4 mem fetch");
        run(1, 0, 1, 0, 12, 2, "R3 io in mode 0");

        // all-memory modes
        cfg(2'd2, 4'd1, 4'd4, 4'd2);
        run(0, 1, 1, 0, 12, 4, "R6 mem read");
        run(0, 1, 0, 0, 12, 4, "R6 mem fetch");
        run(1, 0, 0, 0, 12, 0, "R6 inta");
        run(0, 1, 0, 1, 12, 1, "R7 rom in all mode");
        cfg(2'd3, 4'd1, 4'd4, 4'd2);
        run(0, 1, 1, 0, 12, 4, "R6 mode3 mem read");
        cfg(2'd2, 4'd1, 4'd15, 4'd2);
        run(0, 1, 1, 0, 12, 8, "R9 mem clamp");

        // abort mid-stall then fresh cycle
        cfg(2'd2, 4'd1, 4'd5, 4'd2);
        run(0, 1, 1, 0, 3, 2, "R11 abort");
        cfg(2'd2, 4'd1, 4'd1, 4'd2);
        run(0, 1, 1, 0, 12, 1, "R11 after abort");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R10 scoreboard: pending=%0d exp=0", exp_q.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule